// File: doc/BRIEF.md
# Receive-Side Latency Report Generator

This block sits on the receive side of a network interface. When a packet has fully arrived, it looks at the decoded header. The header supplies a service code, a monitoring flag, a task identifier, a send timestamp and a payload length. If the packet is a message delivery and the monitoring flag is set, the block works out how long the message spent in transit. It then builds a short report packet and sends it to the manager of the receiving element as a stream of 16-bit flits. No processor takes part in this.

Latency is the local free-running cycle counter at the acceptance of the last flit minus the timestamp in the header, taken modulo 2^32. Reports wait in a small queue. If the queue is full, only a flagged delivery is held back at the receive port. Any other packet is always accepted. The manager's address sits in a register that is loaded once during initialization, and every report carries it as its destination.

Top module: `latency_report_gen`

## Requirements
- R1: A report is built only when a completed packet (`rx_done` high while `rx_ready` is high) has service code 0x0012 and `rx_mon` set. A packet with any other code, or with the flag clear, produces no flits.
- R2: A report is exactly 7 flits. In order, they are: manager address, size flit holding 5 (the number of flits that follow it), report service code 0x0071, task identifier, latency bits 31:16, latency bits 15:0, message length.
- R3: The reported latency equals `now_cnt - rx_stamp` modulo 2^32, with `now_cnt` sampled in the acceptance cycle. It wraps correctly when the stamp is larger than the counter.
- R4: `flit_eop` is high on the seventh flit of every report and low on the other six.
- R5: When the output is idle, the first flit of a report is valid in the cycle after acceptance. While `flit_valid` is high and `flit_ready` is low, data and end marker hold steady.
- R6: Two accepted reports can wait at once. A third flagged delivery sees `rx_ready` low until a report has been fully sent, and a packet that needs no report is never stalled.
- R7: The manager address register resets to 0. It takes `mgr_addr` whenever `mgr_load` is high, and each report uses the value held when its first flit goes out.
- R8: During and straight after reset, `flit_valid` is low and `rx_ready` is high.
- R9: Reports leave in acceptance order, back to back, with no idle cycle between them when `flit_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgr_load | input | 1 | Load strobe for the manager address register |
| mgr_addr | input | 16 | Manager address to load |
| now_cnt | input | 32 | Free-running local cycle counter |
| rx_done | input | 1 | Last flit of a packet is present, header fields valid |
| rx_svc | input | 16 | Decoded service code |
| rx_mon | input | 1 | Monitoring flag from the header |
| rx_task | input | 16 | Task identifier from the header |
| rx_stamp | input | 32 | Send timestamp from the header |
| rx_len | input | 16 | Message payload length |
| rx_ready | output | 1 | Packet may complete this cycle |
| flit_data | output | 16 | Report flit |
| flit_valid | output | 1 | Report flit valid |
| flit_eop | output | 1 | Last flit of the report |
| flit_ready | input | 1 | Downstream accepts the flit |

## Verification
A report's first flit is due one cycle after the edge that accepts the flagged packet. After that, one flit goes out on each edge where `flit_ready` is high. The bench drives inputs on the falling edge and decides acceptance from `rx_ready` just before the rising edge. It then pushes the seven expected flits into a queue, using the counter value of that cycle for the latency. A monitor samples on the falling edge and pops one entry for every flit handshake. A directed check reads `flit_valid` and the first flit on the falling edge right after acceptance. When the output is held back, the monitor compares each stalled flit with the one from the cycle before.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
  localparam int FLIT_W  = 16;
  localparam int STAMP_W = 32;

  typedef struct packed {
    logic [FLIT_W-1:0]  task_id;
    logic [STAMP_W-1:0] latency;
    logic [FLIT_W-1:0]  msg_len;
  } rpt_t;

  localparam int RPT_W = $bits(rpt_t);

  // transit time, wraps modulo 2^STAMP_W
  function automatic logic [STAMP_W-1:0] elapsed(input logic [STAMP_W-1:0] now,
                                                 input logic [STAMP_W-1:0] sent);
    return now - sent;
  endfunction

  // flit at position idx of a report
  function automatic logic [FLIT_W-1:0] report_flit(input logic [2:0] idx,
                                                    input logic [FLIT_W-1:0] dest,
                                                    input logic [FLIT_W-1:0] size_val,
                                                    input logic [FLIT_W-1:0] svc,
                                                    input rpt_t r);
    case (idx)
      3'd0:    return dest;
      3'd1:    return size_val;
      3'd2:    return svc;
      3'd3:    return r.task_id;
      3'd4:    return r.latency[STAMP_W-1:FLIT_W];
      3'd5:    return r.latency[FLIT_W-1:0];
      default: return r.msg_len;
    endcase
  endfunction
endpackage

// File: rtl/lrg_fifo.sv
module lrg_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign count = cnt;
endmodule

// File: rtl/lrg_serializer.sv
module lrg_serializer
  import lrg_pkg::*;
#(
  parameter int               NFLITS = 7,
  parameter logic [FLIT_W-1:0] SVC   = 16'h0071
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              have,
  input  rpt_t              head,
  input  logic [FLIT_W-1:0] dest,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_eop,
  output logic              pop
);
  localparam int IW = $clog2(NFLITS);
  localparam logic [IW-1:0]     LAST     = IW'(NFLITS - 1);
  localparam logic [FLIT_W-1:0] SIZE_VAL = FLIT_W'(NFLITS - 2);

  logic [IW-1:0] idx;
  logic          step;

  assign out_valid = have;
  assign step      = have && out_ready;
  assign out_eop   = have && (idx == LAST);
  assign pop       = step && (idx == LAST);
  assign out_data  = report_flit(3'(idx), dest, SIZE_VAL, SVC, head);

  always_ff @(posedge clk) begin
    if (!rst_n)     idx <= '0;
    else if (pop)   idx <= '0;
    else if (step)  idx <= idx + IW'(1);
  end
endmodule

// File: rtl/latency_report_gen.sv
module latency_report_gen
  import lrg_pkg::*;
#(
  parameter int               QDEPTH        = 2,
  parameter logic [FLIT_W-1:0] DELIVERY_CODE = 16'h0012,
  parameter logic [FLIT_W-1:0] REPORT_CODE   = 16'h0071
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgr_load,
  input  logic [FLIT_W-1:0] mgr_addr,
  input  logic [STAMP_W-1:0] now_cnt,
  input  logic              rx_done,
  input  logic [FLIT_W-1:0] rx_svc,
  input  logic              rx_mon,
  input  logic [FLIT_W-1:0] rx_task,
  input  logic [STAMP_W-1:0] rx_stamp,
  input  logic [FLIT_W-1:0] rx_len,
  output logic              rx_ready,
  output logic [FLIT_W-1:0] flit_data,
  output logic              flit_valid,
  output logic              flit_eop,
  input  logic              flit_ready
);
  localparam int NFLITS = 7;
  localparam int CW     = $clog2(QDEPTH + 1);

  // named events for the checker
  logic          rx_want, push, pop, fifo_full, fifo_empty;
  logic [CW-1:0] fifo_cnt;
  rpt_t          new_rpt, head_rpt;
  logic [RPT_W-1:0] head_bits;
  logic [FLIT_W-1:0] mgr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        mgr_q <= '0;
    else if (mgr_load) mgr_q <= mgr_addr;
  end

  assign rx_want  = rx_done && rx_mon && (rx_svc == DELIVERY_CODE);
  assign rx_ready = !(rx_want && fifo_full);
  assign push     = rx_want && !fifo_full;

  always_comb begin
    new_rpt.task_id = rx_task;
    new_rpt.latency = elapsed(now_cnt, rx_stamp);
    new_rpt.msg_len = rx_len;
  end

  lrg_fifo #(.WIDTH(RPT_W), .DEPTH(QDEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (new_rpt),
    .pop   (pop),
    .rdata (head_bits),
    .full  (fifo_full),
    .empty (fifo_empty),
    .count (fifo_cnt)
  );

  assign head_rpt = rpt_t'(head_bits);

  lrg_serializer #(.NFLITS(NFLITS), .SVC(REPORT_CODE)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .have      (!fifo_empty),
    .head      (head_rpt),
    .dest      (mgr_q),
    .out_ready (flit_ready),
    .out_data  (flit_data),
    .out_valid (flit_valid),
    .out_eop   (flit_eop),
    .pop       (pop)
  );
endmodule

// File: rtl/lrg_checker.sv
module lrg_checker #(
  parameter int DEPTH = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_done,
  input logic        rx_ready,
  input logic        push,
  input logic        pop,
  input logic        fifo_full,
  input logic        fifo_empty,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic        flit_valid,
  input logic        flit_ready,
  input logic        flit_eop,
  input logic [15:0] flit_data
);
  localparam int CW = $clog2(DEPTH + 1);

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && !flit_ready |=> flit_valid && $stable(flit_data) && $stable(flit_eop)); // R5
  AST_REPORT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    push && fifo_empty |=> flit_valid); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH)); // R6
  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_ready |-> fifo_full); // R6
  AST_EOP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && flit_ready && flit_eop |=> !(flit_valid && flit_eop)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> fifo_cnt == $past(fifo_cnt) + CW'(1)); // R9
endmodule

bind latency_report_gen lrg_checker #(.DEPTH(QDEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_done    (rx_done),
  .rx_ready   (rx_ready),
  .push       (push),
  .pop        (pop),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_cnt   (fifo_cnt),
  .flit_valid (flit_valid),
  .flit_ready (flit_ready),
  .flit_eop   (flit_eop),
  .flit_data  (flit_data)
);

// File: tb/latency_report_gen_tb.sv
module latency_report_gen_tb;
  localparam logic [15:0] DELIV = 16'h0012;
  localparam logic [15:0] RCODE = 16'h0071;

  logic        clk = 0, rst_n = 0;
  logic        mgr_load = 0;
  logic [15:0] mgr_addr = '0;
  logic [31:0] now_cnt = 32'h0000_1000;
  logic        rx_done = 0, rx_mon = 0;
  logic [15:0] rx_svc = '0, rx_task = '0, rx_len = '0;
  logic [31:0] rx_stamp = '0;
  logic        rx_ready;
  logic [15:0] flit_data;
  logic        flit_valid, flit_eop;
  logic        flit_ready = 1;

  int errors = 0, checks = 0;
  int mode = 0;            // 0 open, 1 closed, 2 throttled
  int tick = 0;
  logic [15:0] mgr_model = '0;
  bit mon_on = 0;

  logic [15:0] exp_d[$];
  bit          exp_e[$];
  string       exp_t[$];

  latency_report_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mgr_load(mgr_load), .mgr_addr(mgr_addr),
    .now_cnt(now_cnt), .rx_done(rx_done), .rx_svc(rx_svc), .rx_mon(rx_mon),
    .rx_task(rx_task), .rx_stamp(rx_stamp), .rx_len(rx_len), .rx_ready(rx_ready),
    .flit_data(flit_data), .flit_valid(flit_valid), .flit_eop(flit_eop),
    .flit_ready(flit_ready)
  );

  always #5 clk = ~clk;
  always @(negedge clk) now_cnt <= now_cnt + 32'd1;
  always @(posedge clk) begin
    tick <= tick + 1;
    #1 flit_ready <= (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : tick[0] & ~tick[2];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_report(input logic [15:0] tid, input logic [31:0] lat, input logic [15:0] len);
    logic [15:0] f [7];
    f[0] = mgr_model; f[1] = 16'd5; f[2] = RCODE; f[3] = tid;
    f[4] = lat[31:16]; f[5] = lat[15:0]; f[6] = len;
    for (int i = 0; i < 7; i++) begin
      exp_d.push_back(f[i]);
      exp_e.push_back(i == 6);
      exp_t.push_back(i == 0 ? "R7" : (i == 4 || i == 5) ? "R3" : "R2");
    end
  endtask

  // drive one completed packet; waits until accepted
  task automatic send(input logic [15:0] svc, input bit flag, input logic [15:0] tid,
                      input logic [31:0] stamp, input logic [15:0] len);
    bit took = 0;
    @(negedge clk);
    rx_svc = svc; rx_mon = flag; rx_task = tid; rx_stamp = stamp; rx_len = len; rx_done = 1;
    while (!took) begin
      #2;
      took = rx_ready;
      if (took && svc == DELIV && flag) expect_report(tid, now_cnt - stamp, len);
      @(negedge clk);
    end
    rx_done = 0;
  endtask

  // monitor: pops the scoreboard on each flit handshake
  logic [15:0] held_d; bit held_e; bit held = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (held) begin
        check(flit_valid && flit_data == held_d && flit_eop == held_e, "R5 hold",
              {15'd0, flit_eop, flit_data}, {15'd0, held_e, held_d});
      end
      held = flit_valid && !flit_ready;
      held_d = flit_data; held_e = flit_eop;
      if (flit_valid && flit_ready) begin
        if (exp_d.size() == 0) begin
          check(0, "R1 unexpected flit", {16'd0, flit_data}, 32'd0);
        end else begin
          logic [15:0] d; bit e; string t;
          d = exp_d.pop_front(); e = exp_e.pop_front(); t = exp_t.pop_front();
          check(flit_data == d, t, {16'd0, flit_data}, {16'd0, d});
          check(flit_eop == e, "R4", {31'd0, flit_eop}, {31'd0, e});
        end
      end
    end
  end

  task automatic drain();
    int n = 0;
    mode = 0;
    while (exp_d.size() != 0 && n < 300) begin @(negedge clk); n++; end
    check(exp_d.size() == 0, "R9 drain", exp_d.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run();
    // R8 reset state
    repeat (3) @(negedge clk);
    check(flit_valid == 0, "R8 valid in reset", {31'd0, flit_valid}, 0);
    check(rx_ready == 1, "R8 ready in reset", {31'd0, rx_ready}, 1);
    rst_n = 1; mon_on = 1;
    @(negedge clk);
    check(flit_valid == 0, "R8 valid after reset", {31'd0, flit_valid}, 0);

    // R7 reset address is 0, then first report starts next cycle (R5)
    send(DELIV, 1, 16'h0A01, now_cnt - 32'd40, 16'd64);
    check(flit_valid == 1, "R5 first flit due", {31'd0, flit_valid}, 1);
    check(flit_data == 16'h0000, "R7 reset address", {16'd0, flit_data}, 0);
    drain();

    // R7 load address
    @(negedge clk); mgr_load = 1; mgr_addr = 16'h0123;
    @(negedge clk); mgr_load = 0; mgr_model = 16'h0123;

    // R1 non-reporting packets
    send(DELIV, 0, 16'h0B01, 32'd5, 16'd8);
    send(16'h0013, 1, 16'h0B02, 32'd5, 16'd8);
    repeat (4) @(negedge clk);
    check(flit_valid == 0, "R1 no report", {31'd0, flit_valid}, 0);

    // R3 normal and wrapping latency, R9 back to back
    send(DELIV, 1, 16'h0C01, now_cnt - 32'h0001_2345, 16'd300);
    send(DELIV, 1, 16'h0C02, 32'hFFFF_FFF0, 16'd12);
    drain();

    // R6 queue full stalls flagged, not unflagged
    mode = 1;
    send(DELIV, 1, 16'h0D01, now_cnt - 32'd7, 16'd1);
    send(DELIV, 1, 16'h0D02, now_cnt - 32'd9, 16'd2);
    @(negedge clk);
    rx_svc = DELIV; rx_mon = 1; rx_done = 1; #2;
    check(rx_ready == 0, "R6 flagged stalled when full", {31'd0, rx_ready}, 0);
    rx_mon = 0; #1;
    check(rx_ready == 1, "R6 unflagged never stalled", {31'd0, rx_ready}, 1);
    rx_done = 0;
    fork
      send(DELIV, 1, 16'h0D03, 32'h0000_0100, 16'd3);
      begin repeat (6) @(negedge clk); mode = 2; end
    join
    drain();

    // R7 reload, throttled output (R5 hold)
    @(negedge clk); mgr_load = 1; mgr_addr = 16'h0456;
    @(negedge clk); mgr_load = 0; mgr_model = 16'h0456;
    mode = 2;
    send(DELIV, 1, 16'h0E01, now_cnt - 32'd1000, 16'd77);
    send(DELIV, 1, 16'h0E02, now_cnt, 16'd0);
    drain();
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule